// File: doc/BRIEF.md
# Ordered Supply Enable Sequencer

This block drives the enable pins of up to six external supplies so that they come up, and go down, in an order set by configuration. Every channel is given a participation flag and a 3-bit slot number. Slots are visited in ascending order on the way up. On the way down the slots are visited in ascending or descending order. Channels that share a slot switch in the same clock cycle. Before each slot the block waits a programmed delay. After the enables of a slot are driven it does not move on until those supplies report that they have reached their levels.

The block sees the analog side only through digital flags. Each channel has an above-threshold flag, a below-off-level flag and a slew-complete flag for gate-drive channels. Requests reach the block from four sources: a power control pin, an active-low forced-shutdown pin, a strobed command byte and per-channel fault masks. Every delay is counted in pulses of a `tick` input. Each enable output has its own polarity.

The controller is one state machine with seven states:
- `S_IDLE`: everything off.
- `S_UP_WAIT`: the delay before a slot turns on.
- `S_UP_CHECK`: waiting for the slot's supplies to become good.
- `S_ON`: fully powered.
- `S_DN_WAIT`: the delay before a slot turns off.
- `S_DN_CHECK`: waiting for the slot's supplies to fall.
- `S_SHUT`: latched forced shutdown.

The named transitions are:
- start: `S_IDLE`→`S_UP_WAIT`
- delay-out: `S_UP_WAIT`→`S_UP_CHECK`
- step-up: `S_UP_CHECK`→`S_UP_WAIT`
- complete: `S_UP_CHECK`→`S_ON`
- begin-off: `S_ON`→`S_DN_WAIT`
- drop: `S_DN_WAIT`→`S_DN_CHECK`
- step-down: `S_DN_CHECK`→`S_DN_WAIT`
- finish-off: `S_DN_CHECK`→`S_IDLE`
- kill: any state→`S_IDLE` or `S_SHUT`
- release: `S_SHUT`→`S_IDLE`

Top module: `pwr_seq_ctrl`

## Requirements
- R1: After reset every enable is inactive, `busy` is 0, `seq_done` is 0 and `position` is 0.
- R2: Power-up starts only from idle, and only on one of two requests: a rising edge of `pwr_pin`, or a command write with bit 7 set. It also requires every channel marked in `cfg_precond` to report above threshold. A request that arrives while this condition fails is dropped. A `pwr_pin` held high through reset counts as a rising edge.
- R3: Each slot waits a delay of `BASE_TICKS << code` ticks. When `cfg_fast` is 1 this value is shifted right by 4. The code is the largest on-delay code (or, going down, off-delay code) among the slot's members. After the delay the enables of all members of the slot become active in the same cycle.
- R4: The sequencer moves past a slot only after every member reports above threshold. Members flagged in `cfg_hv` must also report slew-complete.
- R5: A channel with its participate bit clear, or with slot 7, is never made active by the sequencer.
- R6: `seq_done` pulses for one cycle when the highest used slot is powered and good. In that cycle `busy` is 0. `position` shows the slot being worked on.
- R7: In the fully-on state, power-down is requested by any of three events: a falling edge of `pwr_pin`, a command write with bit 6 set, or a channel in `cfg_off_mask` that is in the sequence and not above threshold.
- R8: Power-down visits the slots from highest to lowest when `cfg_rev_off` is 1, and from lowest to highest when it is 0. Each slot waits its off delay and then drops its members. When `cfg_off_sense` is 1, the slot advances only after all of its members report below the off level. When `cfg_off_sense` is 0, it advances at once.
- R9: Power-down requests made during power-up are dropped. Power-up requests made during power-down are dropped.
- R10: Any of these makes every enable inactive on the next clock edge, from any state: `fs_n_pin` low, a command write with bit 5 set, or, in the fully-on state, a channel in `cfg_fs_mask` that is in the sequence and not above threshold.
- R11: A forced shutdown taken while `cfg_fs_latch` and `cfg_off_sense` are both 1 holds the block off. The hold ends when every sequenced channel reports below the off level, and power-up requests are dropped until then. When either bit is 0 the block is ready to start again right away.
- R12: Output `en_out[i]` equals the internal active state when `cfg_pol[i]` is 1. It equals the inverse of that state when `cfg_pol[i]` is 0.
- R13: Delay counters move only in cycles where `tick` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | asynchronous active-low reset |
| tick | input | 1 | timebase pulse for delays |
| pwr_pin | input | 1 | power control level (rise = up, fall = down) |
| fs_n_pin | input | 1 | forced shutdown, active low |
| cmd_wr | input | 1 | command byte strobe |
| cmd_data | input | 8 | command byte: bit 7 up, bit 6 down, bit 5 shutdown |
| cfg_part | input | NCH | participate bit per channel |
| cfg_pos | input | 3*NCH | slot number per channel, 7 = null |
| cfg_on_dly | input | 2*NCH | on-delay code per channel |
| cfg_off_dly | input | 2*NCH | off-delay code per channel |
| cfg_hv | input | NCH | channel needs slew-complete to count as good |
| cfg_pol | input | NCH | 1 = active-high enable |
| cfg_precond | input | NCH | channels that must be good before start |
| cfg_off_mask | input | NCH | faults that request power-down |
| cfg_fs_mask | input | NCH | faults that force shutdown |
| cfg_fast | input | 1 | divide delays by 16 |
| cfg_rev_off | input | 1 | reverse power-down order |
| cfg_off_sense | input | 1 | wait for off level during power-down |
| cfg_fs_latch | input | 1 | latch forced shutdown |
| ch_above | input | NCH | supply above threshold |
| ch_below_off | input | NCH | supply below off level |
| ch_slew_done | input | NCH | gate drive finished slewing |
| en_out | output | NCH | supply enables after polarity |
| busy | output | 1 | up or down sequence in progress |
| seq_done | output | 1 | one-cycle power-up complete pulse |
| position | output | 3 | current slot |

## Verification
The bench builds the block with six channels and `BASE_TICKS` set to 32. With these values the fast delay codes take 2 to 16 ticks, and `tick` is held high for most of the run. Full up and down walks, stalls on a single rail and latched shutdowns therefore each finish in a few hundred cycles. The same setting leaves the slow code-0 delay at 32 ticks. That is long enough to check the timing window of the slow path and the fast divide in one run, and to freeze the timer by holding `tick` low.

// File: rtl/pwr_seq_pkg.sv
package pwr_seq_pkg;
    localparam int POS_W = 3;
    localparam logic [POS_W-1:0] POS_NULL = 3'd7;
    localparam int CMD_UP   = 7;
    localparam int CMD_DOWN = 6;
    localparam int CMD_KILL = 5;

    typedef enum logic [2:0] {
        S_IDLE,
        S_UP_WAIT,
        S_UP_CHECK,
        S_ON,
        S_DN_WAIT,
        S_DN_CHECK,
        S_SHUT
    } seq_state_t;
endpackage

// File: rtl/pwr_seq_trig.sv
module pwr_seq_trig
    import pwr_seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pwr_pin,
    input  logic       fs_n_pin,
    input  logic       cmd_wr,
    input  logic [7:0] cmd_data,
    input  logic       fault_down,
    input  logic       fault_kill,
    output logic       up_req,
    output logic       down_req,
    output logic       kill_req
);
    logic pin_q;

    // pin_q resets low so a pin held high through reset reads as a start edge
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pin_q <= 1'b0;
        else        pin_q <= pwr_pin;
    end

    always_comb begin
        up_req   = (pwr_pin & ~pin_q) | (cmd_wr & cmd_data[CMD_UP]);
        down_req = (~pwr_pin & pin_q) | (cmd_wr & cmd_data[CMD_DOWN]) | fault_down;
        kill_req = ~fs_n_pin | (cmd_wr & cmd_data[CMD_KILL]) | fault_kill;
    end
endmodule

// File: rtl/pwr_seq_timer.sv
module pwr_seq_timer #(
    parameter int BASE_TICKS = 400
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       load,
    input  logic [1:0] code,
    input  logic       fast,
    output logic       done
);
    localparam int DW = $clog2(BASE_TICKS * 8 + 1);

    logic [DW-1:0] cnt;
    logic [DW-1:0] span;

    always_comb begin
        span = DW'(BASE_TICKS) << code;
        if (fast) span = span >> 4;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                   cnt <= '0;
        else if (load)                cnt <= span;
        else if (tick && cnt != '0)   cnt <= cnt - 1'b1;
    end

    assign done = (cnt == '0);
endmodule

// File: rtl/pwr_seq_slot.sv
module pwr_seq_slot
    import pwr_seq_pkg::*;
#(
    parameter int NCH = 6
) (
    input  logic [NCH-1:0]       part,
    input  logic [NCH*POS_W-1:0] pos_flat,
    input  logic [2*NCH-1:0]     on_code_flat,
    input  logic [2*NCH-1:0]     off_code_flat,
    input  logic [NCH-1:0]       hv,
    input  logic [NCH-1:0]       above,
    input  logic [NCH-1:0]       below,
    input  logic [NCH-1:0]       slew,
    input  logic [POS_W-1:0]     cur_pos,
    input  logic [POS_W-1:0]     qry_pos,
    output logic [NCH-1:0]       seq_mask,
    output logic [NCH-1:0]       member,
    output logic [POS_W-1:0]     top_pos,
    output logic                 any_seq,
    output logic [1:0]           qry_on_code,
    output logic [1:0]           qry_off_code,
    output logic                 up_ok,
    output logic                 dn_ok,
    output logic                 all_below
);
    logic [POS_W-1:0] ch_pos [NCH];
    logic [NCH-1:0]   qry_mem;
    logic [NCH-1:0]   good;

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        assign ch_pos[i]   = pos_flat[i*POS_W +: POS_W];
        assign seq_mask[i] = part[i] && (ch_pos[i] != POS_NULL);
        assign member[i]   = seq_mask[i] && (ch_pos[i] == cur_pos);
        assign qry_mem[i]  = seq_mask[i] && (ch_pos[i] == qry_pos);
        assign good[i]     = above[i] && (!hv[i] || slew[i]);
    end

    // highest used slot and the longest delay code inside the queried slot
    always_comb begin
        top_pos      = '0;
        qry_on_code  = 2'd0;
        qry_off_code = 2'd0;
        for (int i = 0; i < NCH; i++) begin
            if (seq_mask[i] && ch_pos[i] > top_pos)
                top_pos = ch_pos[i];
            if (qry_mem[i] && on_code_flat[2*i +: 2] > qry_on_code)
                qry_on_code = on_code_flat[2*i +: 2];
            if (qry_mem[i] && off_code_flat[2*i +: 2] > qry_off_code)
                qry_off_code = off_code_flat[2*i +: 2];
        end
    end

    assign any_seq   = |seq_mask;
    assign up_ok     = &(good  | ~member);
    assign dn_ok     = &(below | ~member);
    assign all_below = &(below | ~seq_mask);
endmodule

// File: rtl/pwr_seq_drive.sv
module pwr_seq_drive #(
    parameter int NCH = 6
) (
    input  logic [NCH-1:0] act,
    input  logic [NCH-1:0] pol,
    output logic [NCH-1:0] pin
);
    for (genvar i = 0; i < NCH; i++) begin : g_pol
        // active-high: follow the state; active-low: invert it
        assign pin[i] = pol[i] ? act[i] : ~act[i];
    end
endmodule

// File: rtl/pwr_seq_ctrl.sv
module pwr_seq_ctrl
    import pwr_seq_pkg::*;
#(
    parameter int NCH        = 6,
    parameter int BASE_TICKS = 400
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 tick,
    input  logic                 pwr_pin,
    input  logic                 fs_n_pin,
    input  logic                 cmd_wr,
    input  logic [7:0]           cmd_data,
    input  logic [NCH-1:0]       cfg_part,
    input  logic [NCH*POS_W-1:0] cfg_pos,
    input  logic [2*NCH-1:0]     cfg_on_dly,
    input  logic [2*NCH-1:0]     cfg_off_dly,
    input  logic [NCH-1:0]       cfg_hv,
    input  logic [NCH-1:0]       cfg_pol,
    input  logic [NCH-1:0]       cfg_precond,
    input  logic [NCH-1:0]       cfg_off_mask,
    input  logic [NCH-1:0]       cfg_fs_mask,
    input  logic                 cfg_fast,
    input  logic                 cfg_rev_off,
    input  logic                 cfg_off_sense,
    input  logic                 cfg_fs_latch,
    input  logic [NCH-1:0]       ch_above,
    input  logic [NCH-1:0]       ch_below_off,
    input  logic [NCH-1:0]       ch_slew_done,
    output logic [NCH-1:0]       en_out,
    output logic                 busy,
    output logic                 seq_done,
    output logic [POS_W-1:0]     position
);
    seq_state_t       state, state_n;
    logic [POS_W-1:0] pos, pos_n;
    logic [NCH-1:0]   en_act, en_n;
    logic             done_n;
    logic             t_load, t_off, t_done;
    logic [1:0]       t_code;

    logic [NCH-1:0]   seq_mask, member;
    logic [POS_W-1:0] top_pos;
    logic             any_seq, up_ok, dn_ok, all_below;
    logic [1:0]       qry_on_code, qry_off_code;
    logic             up_req, down_req, kill_req;
    logic             fault_down, fault_kill, precond_ok;
    logic [POS_W-1:0] dn_first, dn_last;

    assign fault_down = (state == S_ON) && |(cfg_off_mask & seq_mask & ~ch_above);
    assign fault_kill = (state == S_ON) && |(cfg_fs_mask  & seq_mask & ~ch_above);
    assign precond_ok = &(ch_above | ~cfg_precond);
    assign dn_first   = cfg_rev_off ? top_pos : '0;
    assign dn_last    = cfg_rev_off ? '0 : top_pos;
    assign t_code     = t_off ? qry_off_code : qry_on_code;

    pwr_seq_trig u_trig (
        .clk        (clk),
        .rst_n      (rst_n),
        .pwr_pin    (pwr_pin),
        .fs_n_pin   (fs_n_pin),
        .cmd_wr     (cmd_wr),
        .cmd_data   (cmd_data),
        .fault_down (fault_down),
        .fault_kill (fault_kill),
        .up_req     (up_req),
        .down_req   (down_req),
        .kill_req   (kill_req)
    );

    pwr_seq_slot #(.NCH(NCH)) u_slot (
        .part          (cfg_part),
        .pos_flat      (cfg_pos),
        .on_code_flat  (cfg_on_dly),
        .off_code_flat (cfg_off_dly),
        .hv            (cfg_hv),
        .above         (ch_above),
        .below         (ch_below_off),
        .slew          (ch_slew_done),
        .cur_pos       (pos),
        .qry_pos       (pos_n),
        .seq_mask      (seq_mask),
        .member        (member),
        .top_pos       (top_pos),
        .any_seq       (any_seq),
        .qry_on_code   (qry_on_code),
        .qry_off_code  (qry_off_code),
        .up_ok         (up_ok),
        .dn_ok         (dn_ok),
        .all_below     (all_below)
    );

    pwr_seq_timer #(.BASE_TICKS(BASE_TICKS)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick),
        .load  (t_load),
        .code  (t_code),
        .fast  (cfg_fast),
        .done  (t_done)
    );

    pwr_seq_drive #(.NCH(NCH)) u_drive (
        .act (en_act),
        .pol (cfg_pol),
        .pin (en_out)
    );

    // state register and sequencing datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state    <= S_IDLE;
            pos      <= '0;
            en_act   <= '0;
            seq_done <= 1'b0;
        end else begin
            state    <= state_n;
            pos      <= pos_n;
            en_act   <= en_n;
            seq_done <= done_n;
        end
    end

    // next state
    always_comb begin
        state_n = state;
        pos_n   = pos;
        en_n    = en_act;
        done_n  = 1'b0;
        t_load  = 1'b0;
        t_off   = 1'b0;
        unique case (state)
            S_IDLE: begin
                if (up_req && !kill_req && precond_ok && any_seq) begin
                    state_n = S_UP_WAIT;     // start
                    pos_n   = '0;
                    t_load  = 1'b1;
                end
            end
            S_UP_WAIT: begin
                if (t_done) begin
                    en_n    = en_act | member;
                    state_n = S_UP_CHECK;    // delay-out
                end
            end
            S_UP_CHECK: begin
                if (up_ok) begin
                    if (pos == top_pos) begin
                        state_n = S_ON;      // complete
                        done_n  = 1'b1;
                    end else begin
                        state_n = S_UP_WAIT; // step-up
                        pos_n   = pos + 1'b1;
                        t_load  = 1'b1;
                    end
                end
            end
            S_ON: begin
                if (down_req) begin
                    state_n = S_DN_WAIT;     // begin-off
                    pos_n   = dn_first;
                    t_load  = 1'b1;
                    t_off   = 1'b1;
                end
            end
            S_DN_WAIT: begin
                t_off = 1'b1;
                if (t_done) begin
                    en_n    = en_act & ~member;
                    state_n = S_DN_CHECK;    // drop
                end
            end
            S_DN_CHECK: begin
                t_off = 1'b1;
                if (!cfg_off_sense || dn_ok) begin
                    if (pos == dn_last) begin
                        state_n = S_IDLE;    // finish-off
                        pos_n   = '0;
                    end else begin
                        state_n = S_DN_WAIT; // step-down
                        pos_n   = cfg_rev_off ? pos - 1'b1 : pos + 1'b1;
                        t_load  = 1'b1;
                    end
                end
            end
            S_SHUT: begin
                if (all_below) state_n = S_IDLE; // release
            end
            default: state_n = S_IDLE;
        endcase
        if (kill_req) begin                      // kill
            en_n    = '0;
            pos_n   = '0;
            done_n  = 1'b0;
            t_load  = 1'b0;
            state_n = (cfg_fs_latch && cfg_off_sense) ? S_SHUT : S_IDLE;
        end
    end

    // outputs
    always_comb begin
        unique case (state)
            S_UP_WAIT, S_UP_CHECK, S_DN_WAIT, S_DN_CHECK: busy = 1'b1;
            default:                                      busy = 1'b0;
        endcase
        position = pos;
    end
endmodule

// File: rtl/pwr_seq_ctrl_chk.sv
module pwr_seq_ctrl_chk
    import pwr_seq_pkg::*;
#(
    parameter int NCH = 6
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 fs_n_pin,
    input logic [NCH-1:0]       cfg_part,
    input logic [NCH*POS_W-1:0] cfg_pos,
    input logic [NCH-1:0]       cfg_pol,
    input logic [NCH-1:0]       en_out,
    input logic                 busy,
    input logic                 seq_done
);
    logic [NCH-1:0] act;
    assign act = en_out ~^ cfg_pol;

    for (genvar i = 0; i < NCH; i++) begin : g_null
        assert_null_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
            (!cfg_part[i] || cfg_pos[i*POS_W +: POS_W] == POS_NULL) |-> !act[i]);
    end

    assert_kill_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !fs_n_pin |=> (act == '0));

    assert_done_not_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
        seq_done |-> !busy);

    assert_done_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        seq_done |=> !seq_done);
endmodule

bind pwr_seq_ctrl pwr_seq_ctrl_chk #(.NCH(NCH)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .fs_n_pin (fs_n_pin),
    .cfg_part (cfg_part),
    .cfg_pos  (cfg_pos),
    .cfg_pol  (cfg_pol),
    .en_out   (en_out),
    .busy     (busy),
    .seq_done (seq_done)
);

// File: tb/sim_pwr_seq_ctrl.sv
module sim_pwr_seq_ctrl;
    localparam int NCH  = 6;
    localparam int BASE = 32;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic rst_n = 1'b0;
    logic tick_run = 1'b1;
    logic pwr_pin = 1'b0, fs_n_pin = 1'b1, cmd_wr = 1'b0;
    logic [7:0] cmd_data = 8'h00;
    logic [NCH-1:0] cfg_part = '0, cfg_hv = '0, cfg_pol = '0, cfg_precond = '0;
    logic [NCH-1:0] cfg_off_mask = '0, cfg_fs_mask = '0;
    logic [NCH*3-1:0] cfg_pos = '0;
    logic [2*NCH-1:0] cfg_on_dly = '0, cfg_off_dly = '0;
    logic cfg_fast = 1'b1, cfg_rev_off = 1'b1, cfg_off_sense = 1'b1, cfg_fs_latch = 1'b0;
    logic [NCH-1:0] force_hi = '0, force_lo = '0, stuck_on = '0, slew = '1;
    logic [NCH-1:0] ch_above, ch_below_off, en_out, act;
    logic busy, seq_done;
    logic [2:0] position;

    int checks = 0, errors = 0, cycles = 0;

    assign act          = en_out ~^ cfg_pol;
    assign ch_above     = (act | force_hi) & ~force_lo;
    assign ch_below_off = ~act & ~stuck_on;

    pwr_seq_ctrl #(.NCH(NCH), .BASE_TICKS(BASE)) u0 (
        .clk(clk), .rst_n(rst_n), .tick(tick_run), .pwr_pin(pwr_pin), .fs_n_pin(fs_n_pin),
        .cmd_wr(cmd_wr), .cmd_data(cmd_data), .cfg_part(cfg_part), .cfg_pos(cfg_pos),
        .cfg_on_dly(cfg_on_dly), .cfg_off_dly(cfg_off_dly), .cfg_hv(cfg_hv), .cfg_pol(cfg_pol),
        .cfg_precond(cfg_precond), .cfg_off_mask(cfg_off_mask), .cfg_fs_mask(cfg_fs_mask),
        .cfg_fast(cfg_fast), .cfg_rev_off(cfg_rev_off), .cfg_off_sense(cfg_off_sense),
        .cfg_fs_latch(cfg_fs_latch), .ch_above(ch_above), .ch_below_off(ch_below_off),
        .ch_slew_done(slew), .en_out(en_out), .busy(busy), .seq_done(seq_done),
        .position(position)
    );

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            checks++; errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic check(input bit ok, input string req, input int a, input int e);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, a, e);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send_cmd(input logic [7:0] d);
        @(negedge clk); cmd_wr = 1'b1; cmd_data = d;
        @(negedge clk); cmd_wr = 1'b0; cmd_data = 8'h00;
    endtask

    task automatic wait_done(input int lim, output bit got);
        got = 1'b0;
        for (int k = 0; k < lim && !got; k++) begin
            @(negedge clk);
            if (seq_done) got = 1'b1;
        end
    endtask

    task automatic wait_idle(input int lim);
        for (int k = 0; k < lim && busy; k++) @(negedge clk);
    endtask

    task automatic set_ch(input int i, input bit p, input int ps, input int on, input int off, input bit h);
        cfg_part[i] = p; cfg_pos[i*3 +: 3] = 3'(ps);
        cfg_on_dly[2*i +: 2] = 2'(on); cfg_off_dly[2*i +: 2] = 2'(off); cfg_hv[i] = h;
    endtask

    task automatic kill_all();
        send_cmd(8'h20);
        step(2);
    endtask

    task automatic up_ok(input string req);
        bit got;
        send_cmd(8'h80);
        wait_done(400, got);
        check(got, req, int'(got), 1);
    endtask

    task automatic t_reset();
        check(en_out == ~cfg_pol, "R12 idle levels", int'(en_out), int'(~cfg_pol));
        check(act == '0 && !busy && !seq_done, "R1 reset state", int'(act), 0);
        check(position == 3'd0, "R1 position", int'(position), 0);
    endtask

    task automatic t_precond();
        force_hi[5] = 1'b0;
        send_cmd(8'h80);
        step(20);
        check(!busy && act == '0, "R2 precondition blocks", int'(busy), 0);
        force_hi[5] = 1'b1;
    endtask

    task automatic t_power_up();
        int t_on[NCH];
        bit seen_done = 1'b0;
        bit got;
        foreach (t_on[i]) t_on[i] = -1;
        slew[3] = 1'b0;
        send_cmd(8'h80);
        send_cmd(8'h40);                       // R9: down request during power-up
        for (int k = 0; k < 400 && t_on[3] < 0; k++) begin
            @(negedge clk);
            for (int i = 0; i < NCH; i++) if (act[i] && t_on[i] < 0) t_on[i] = k;
        end
        for (int k = 0; k < 40; k++) begin
            @(negedge clk);
            if (seq_done) seen_done = 1'b1;
        end
        check(!seen_done && busy && position == 3'd2, "R4 slew holds slot", int'(seen_done), 0);
        check(t_on[1] == t_on[2] && t_on[1] >= 0, "R3 shared slot together", t_on[1], t_on[2]);
        check(t_on[0] < t_on[1] && t_on[1] < t_on[3], "R3 ascending order", t_on[1], t_on[0] + 1);
        slew[3] = 1'b1;
        wait_done(20, got);
        check(got, "R6 done pulse", int'(got), 1);
        check(!busy && position == 3'd2, "R6 busy low at done", int'(busy), 0);
        check(act == 6'b001111, "R5 null slot idle", int'(act), 15);
        step(30);
        check(act == 6'b001111, "R9 down request dropped", int'(act), 15);
    endtask

    task automatic record_off(output int t_off[NCH]);
        foreach (t_off[i]) t_off[i] = -1;
        for (int k = 0; k < 600 && (busy || k == 0); k++) begin
            @(negedge clk);
            for (int i = 0; i < 4; i++) if (!act[i] && t_off[i] < 0) t_off[i] = k;
        end
    endtask

    task automatic t_off_reverse();
        int t_off[NCH];
        send_cmd(8'h40);
        record_off(t_off);
        check(t_off[3] < t_off[1] && t_off[1] == t_off[2] && t_off[2] < t_off[0],
              "R8 reverse order", t_off[3], t_off[0]);
        check(act == '0 && !busy && position == 3'd0, "R8 reverse ends idle", int'(act), 0);
    endtask

    task automatic t_pin_forward();
        int t_off[NCH];
        bit got;
        cfg_rev_off = 1'b0;
        @(negedge clk); pwr_pin = 1'b1;
        wait_done(400, got);
        check(got, "R2 pin rise starts", int'(got), 1);
        @(negedge clk); pwr_pin = 1'b0;
        record_off(t_off);
        check(t_off[0] < t_off[1] && t_off[1] == t_off[2] && t_off[2] < t_off[3],
              "R7 R8 pin fall forward order", t_off[0], t_off[3]);
        check(act == '0 && !busy, "R8 forward ends idle", int'(act), 0);
    endtask

    task automatic t_off_sense();
        up_ok("R8 setup up");
        stuck_on[0] = 1'b1;
        send_cmd(8'h40);
        step(80);
        check(!act[0] && act[1] && busy, "R8 waits for off level", int'(act), 14);
        stuck_on[0] = 1'b0;
        wait_idle(300);
        check(act == '0 && !busy, "R8 resumes after off level", int'(act), 0);
        cfg_off_sense = 1'b0;
        up_ok("R8 setup up no sense");
        stuck_on = '1;
        send_cmd(8'h40);
        wait_idle(300);
        check(act == '0 && !busy, "R8 sensors off advance", int'(act), 0);
        stuck_on = '0;
        cfg_off_sense = 1'b1;
    endtask

    task automatic t_fault_down();
        cfg_off_mask = 6'b000010;
        up_ok("R7 setup up");
        @(negedge clk); force_lo[1] = 1'b1;
        step(3);
        check(busy, "R7 masked fault starts down", int'(busy), 1);
        wait_idle(300);
        check(act == '0, "R7 down completes", int'(act), 0);
        force_lo = '0;
        cfg_off_mask = '0;
    endtask

    task automatic t_forced();
        up_ok("R10 setup up");
        @(negedge clk); fs_n_pin = 1'b0;
        @(negedge clk);
        check(act == '0 && !busy, "R10 pin kill", int'(act), 0);
        fs_n_pin = 1'b1;
        cfg_fs_mask = 6'b001000;
        up_ok("R10 setup up 2");
        @(negedge clk); force_lo[3] = 1'b1;
        step(2);
        check(act == '0, "R10 masked fault kill", int'(act), 0);
        force_lo = '0;
        cfg_fs_mask = '0;
    endtask

    task automatic t_latch();
        cfg_fs_latch = 1'b1;
        up_ok("R11 setup up");
        stuck_on[2] = 1'b1;
        send_cmd(8'h20);
        check(act == '0, "R11 command kill", int'(act), 0);
        send_cmd(8'h80);
        step(30);
        check(!busy && act == '0, "R11 latched blocks start", int'(busy), 0);
        stuck_on[2] = 1'b0;
        step(3);
        up_ok("R11 released by off level");
        cfg_off_sense = 1'b0;
        stuck_on[2] = 1'b1;
        send_cmd(8'h20);
        send_cmd(8'h80);
        step(3);
        check(busy, "R11 no latch without sensors", int'(busy), 1);
        cfg_fs_latch = 1'b0;
        stuck_on = '0;
        kill_all();
        cfg_off_sense = 1'b1;
    endtask

    task automatic t_tick();
        bit got;
        tick_run = 1'b0;
        send_cmd(8'h80);
        step(100);
        check(busy && act == '0, "R13 timer frozen", int'(act), 0);
        tick_run = 1'b1;
        wait_done(400, got);
        check(got, "R13 timer resumes", int'(got), 1);
        kill_all();
    endtask

    task automatic t_slow();
        int k_on = -1;
        cfg_fast = 1'b0;
        send_cmd(8'h80);
        for (int k = 1; k < 200 && k_on < 0; k++) begin
            @(negedge clk);
            if (act[0]) k_on = k;
        end
        check(k_on >= 30 && k_on <= 36, "R3 slow code0 delay", k_on, 33);
        kill_all();
        cfg_fast = 1'b1;
    endtask

    initial begin
        cfg_pol = 6'b101010;
        cfg_precond = 6'b100000;
        force_hi = 6'b100000;
        set_ch(0, 1, 0, 0, 0, 0);
        set_ch(1, 1, 1, 1, 0, 0);
        set_ch(2, 1, 1, 0, 1, 0);
        set_ch(3, 1, 2, 0, 0, 1);
        set_ch(4, 1, 7, 0, 0, 0);
        set_ch(5, 0, 0, 0, 0, 0);
        step(3);
        rst_n = 1'b1;
        step(2);
        t_reset();
        t_precond();
        t_power_up();
        t_off_reverse();
        t_pin_forward();
        t_off_sense();
        t_fault_down();
        t_forced();
        t_latch();
        t_tick();
        t_slow();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule